// File: doc/BRIEF.md
# Four-Channel Timer Capture/Compare Unit

This block holds one free-running 16-bit counter and four timer channels, numbered 4 to 7. The counter advances once for each clock cycle in which `tick` is high. Each channel has a mode bit. In capture mode, a chosen edge on the channel's input pin stores the counter value in the channel register and raises the channel flag. In compare mode, the channel acts when the counter reaches its register value: it drives its output pin in the programmed way and raises its flag.

Software can also trigger a compare action at once through a write-only force register. A forced action never raises a flag. It wins over a real match on the same channel in the same cycle, so the action happens only once and the flag stays clear. When channel 7 acts, it can take over any subset of the four output pins and drive them to stored data values. The other channels' actions on those pins are then suppressed.

All registers sit on a single-cycle bus with a 4-bit word address and 16-bit data. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `tmr_cc4`

## Requirements
- R1: After reset the counter, mode bits, action and edge selects, override mask and data, channel registers, flags and output pins are all zero.
- R2: Address 0 holds the mode bits. Bit 4+k belongs to channel 4+k, where 1 means compare and 0 means capture. The register can be read and written at any time, and all other bits read as 0.
- R3: The counter at address 7 increments by one at each clock edge where `tick` is high, wraps from 0xFFFF to 0x0000, and holds otherwise.
- R4: A compare-mode channel matches when `tick` is high and the counter equals its register (addresses 8 to 11 for channels 4 to 7). On a match, from the next cycle its pin follows the 2-bit action at address 2, bits 2k+1:2k for channel 4+k: 00 none, 01 toggle, 10 clear, 11 set. Its flag is also set.
- R5: Writing 1 to bit 4+k of address 1 performs channel 4+k's compare action at that edge without setting its flag. Address 1 always reads 0.
- R6: When a force and a real match hit the same channel in the same cycle, the action is applied once and the flag is not set.
- R7: When channel 7 acts (by match or by force), each pin k with bit 4+k set in the mask at address 4 takes bit 4+k of the data at address 5. This replaces any action on that pin, including channel 7's own.
- R8: A capture-mode channel selects its edge with 2 bits at address 3, bits 2k+1:2k: 00 off, 01 rising, 10 falling, 11 either. On that edge it copies the counter into its register and sets its flag. A capture beats a bus write to that register in the same cycle.
- R9: Flags read at address 6, bits 7:4. Writing 1 to a flag bit clears it, and a set in the same cycle wins over the clear.
- R10: A force on a capture-mode channel changes no pin and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter advance enable |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cap_in | input | 4 | Capture inputs, bit k for channel 4+k |
| pin_o | output | 4 | Compare outputs, bit k for channel 4+k |
| flag_o | output | 4 | Channel flags, bit k for channel 4+k |

## Verification
The assertions assume that `cap_in` is already synchronous to `clk`, because edges are found by comparing it with its value one cycle earlier. They also assume that `tick` and the bus signals are stable around each rising edge. The bench drives every input on the falling edge from a single process, so these assumptions hold. Capture values are produced by ordinary logic, and compare values are written close to the running count so that matches, forces and captures often land in the same cycle.

// File: rtl/tmr_cc4.sv
module tmr_cc4 #(
  parameter int CW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic [3:0]    cap_in,
  output logic [3:0]    pin_o,
  output logic [3:0]    flag_o
);
  localparam int NCH = 4;

  logic [CW-1:0] cnt;
  logic [CW-1:0] chreg [NCH];
  logic [3:0]    mode, mask7, data7, flg, pin, cap_q;
  logic [7:0]    act, edg;
  logic [3:0]    frc, clr, rise, fall, cev, mt, aev, setf;
  logic          ovr;

  assign frc  = (bus_we && bus_addr == AW'(1)) ? bus_wdata[7:4] : 4'b0;
  assign clr  = (bus_we && bus_addr == AW'(6)) ? bus_wdata[7:4] : 4'b0;
  assign rise = cap_in & ~cap_q;
  assign fall = ~cap_in & cap_q;
  assign ovr  = aev[3];
  assign pin_o  = pin;
  assign flag_o = flg;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [1:0] es;
    assign es      = edg[2*i +: 2];
    assign cev[i]  = !mode[i] && ((es == 2'b01 && rise[i]) || (es == 2'b10 && fall[i]) ||
                                  (es == 2'b11 && (rise[i] || fall[i])));
    assign mt[i]   = mode[i] && tick && cnt == chreg[i];
    assign aev[i]  = mt[i] || (mode[i] && frc[i]);
    assign setf[i] = cev[i] || (mt[i] && !frc[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chreg[i] <= '0;
        pin[i]   <= 1'b0;
        flg[i]   <= 1'b0;
      end else begin
        if (cev[i])
          chreg[i] <= cnt;
        else if (bus_we && bus_addr == AW'(8 + i))
          chreg[i] <= bus_wdata;
        if (ovr && mask7[i])
          pin[i] <= data7[i];
        else if (aev[i])
          case (act[2*i +: 2])
            2'b01:   pin[i] <= ~pin[i];
            2'b10:   pin[i] <= 1'b0;
            2'b11:   pin[i] <= 1'b1;
            default: ;
          endcase
        flg[i] <= setf[i] | (flg[i] & ~clr[i]);
      end
    end

    assert_force_noflag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (frc[i] && mode[i] && !flg[i]) |=> !flg[i]);
    assert_override_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (aev[3] && mask7[i]) |=> pin[i] == $past(data7[i]));
    assert_capture_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cev[i] |=> chreg[i] == $past(cnt));
    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !cev[i] && !mt[i]) |=> !flg[i]);
    assert_capture_force_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[i] && !aev[3]) |=> $stable(pin[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      mode  <= '0;
      act   <= '0;
      edg   <= '0;
      mask7 <= '0;
      data7 <= '0;
      cap_q <= '0;
    end else begin
      cap_q <= cap_in;
      if (tick) cnt <= cnt + 1'b1;
      if (bus_we)
        case (bus_addr)
          AW'(0): mode  <= bus_wdata[7:4];
          AW'(2): act   <= bus_wdata[7:0];
          AW'(3): edg   <= bus_wdata[7:0];
          AW'(4): mask7 <= bus_wdata[7:4];
          AW'(5): data7 <= bus_wdata[7:4];
          default: ;
        endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(0):  bus_rdata[7:4] = mode;
      AW'(2):  bus_rdata[7:0] = act;
      AW'(3):  bus_rdata[7:0] = edg;
      AW'(4):  bus_rdata[7:4] = mask7;
      AW'(5):  bus_rdata[7:4] = data7;
      AW'(6):  bus_rdata[7:4] = flg;
      AW'(7):  bus_rdata      = cnt;
      AW'(8):  bus_rdata      = chreg[0];
      AW'(9):  bus_rdata      = chreg[1];
      AW'(10): bus_rdata      = chreg[2];
      AW'(11): bus_rdata      = chreg[3];
      default: ;
    endcase
  end

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == CW'($past(cnt) + 1'b1));
  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  assert_force_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(1)) |-> bus_rdata == '0);
  assert_mode_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(0)) |-> bus_rdata[3:0] == 4'b0);
endmodule

// File: tb/tmr_cc4_test.sv
module tmr_cc4_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick = 0, bus_we = 0;
  logic [3:0] bus_addr = 0, cap_in = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [3:0] pin_o, flag_o;
  int checks = 0, errors = 0;

  logic [15:0] m_cnt;
  logic [15:0] m_ch [4];
  logic [3:0]  m_mode, m_mask, m_data, m_flag, m_pin, m_capq;
  logic [7:0]  m_act, m_edge;

  tmr_cc4 uut (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
               .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
               .pin_o(pin_o), .flag_o(flag_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return {8'h0, m_mode, 4'h0};
      4'd2: return {8'h0, m_act};
      4'd3: return {8'h0, m_edge};
      4'd4: return {8'h0, m_mask, 4'h0};
      4'd5: return {8'h0, m_data, 4'h0};
      4'd6: return {8'h0, m_flag, 4'h0};
      4'd7: return m_cnt;
      4'd8, 4'd9, 4'd10, 4'd11: return m_ch[a - 4'd8];
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic pin_next(input int i, input logic ev, input logic ov);
    if (ov && m_mask[i]) return m_data[i];
    if (!ev) return m_pin[i];
    case (m_act[2*i +: 2])
      2'b01: return ~m_pin[i];
      2'b10: return 1'b0;
      2'b11: return 1'b1;
      default: return m_pin[i];
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_mode = 0; m_mask = 0; m_data = 0; m_flag = 0; m_pin = 0; m_capq = 0;
    m_act = 0; m_edge = 0;
    for (int i = 0; i < 4; i++) m_ch[i] = 0;
  endtask

  task automatic step(input logic we, input logic [3:0] a, input logic [15:0] d,
                      input logic tk, input logic [3:0] cp, input string tag);
    logic [3:0] frc, clr, cev, mt, aev, setf, npin;
    logic [15:0] nch [4];
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; tick = tk; cap_in = cp;
    #1;
    check(tag, $sformatf("read addr %0d", a), bus_rdata, exp_read(a));
    frc = (we && a == 4'd1) ? d[7:4] : 4'h0;
    clr = (we && a == 4'd6) ? d[7:4] : 4'h0;
    for (int i = 0; i < 4; i++) begin
      logic r, f;
      logic [1:0] es;
      r = cp[i] & ~m_capq[i];
      f = ~cp[i] & m_capq[i];
      es = m_edge[2*i +: 2];
      cev[i] = !m_mode[i] && ((es == 2'b01 && r) || (es == 2'b10 && f) || (es == 2'b11 && (r || f)));
      mt[i] = m_mode[i] && tk && m_cnt == m_ch[i];
      aev[i] = mt[i] || (m_mode[i] && frc[i]);
      setf[i] = cev[i] || (mt[i] && !frc[i]);
    end
    for (int i = 0; i < 4; i++) begin
      npin[i] = pin_next(i, aev[i], aev[3]);
      nch[i] = cev[i] ? m_cnt : ((we && a == 4'(8 + i)) ? d : m_ch[i]);
    end
    @(posedge clk);
    #1;
    m_pin = npin;
    m_flag = setf | (m_flag & ~clr);
    for (int i = 0; i < 4; i++) m_ch[i] = nch[i];
    if (we) case (a)
      4'd0: m_mode = d[7:4];
      4'd2: m_act = d[7:0];
      4'd3: m_edge = d[7:0];
      4'd4: m_mask = d[7:4];
      4'd5: m_data = d[7:4];
      default: ;
    endcase
    if (tk) m_cnt = m_cnt + 16'd1;
    m_capq = cp;
    check(tag, "pins", {12'h0, pin_o}, {12'h0, m_pin});
    check(tag, "flags", {12'h0, flag_o}, {12'h0, m_flag});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    for (int a = 0; a < 12; a++) step(0, 4'(a), 0, 0, 0, "R1 reset");
    step(1, 0, 16'hFFFF, 0, 0, "R2");
    step(0, 0, 0, 0, 0, "R2 mode readback");
    step(1, 2, 16'h0055, 0, 0, "R4");
    step(1, 8, m_cnt + 16'd2, 0, 0, "R4");
    for (int k = 0; k < 4; k++) step(0, 6, 0, 1, 0, "R4 match toggle");
    step(1, 6, 16'h00F0, 0, 0, "R9 clear");
    step(1, 1, 16'h0010, 0, 0, "R5 force");
    step(0, 1, 0, 0, 0, "R5 force reads zero");
    step(1, 9, m_cnt, 0, 0, "R6");
    step(1, 1, 16'h0020, 1, 0, "R6 force with match");
    step(0, 6, 0, 0, 0, "R6 flag clear");
    step(1, 4, 16'h00F0, 0, 0, "R7");
    step(1, 5, 16'h00A0, 0, 0, "R7");
    step(1, 1, 16'h0090, 0, 0, "R7 override");
    step(1, 11, m_cnt, 0, 0, "R7");
    step(1, 5, 16'h0050, 1, 0, "R7 override by match");
    step(1, 0, 16'h0000, 0, 0, "R10");
    step(1, 1, 16'h00F0, 0, 0, "R10 force in capture");
    step(1, 3, 16'h00E4, 0, 0, "R8");
    step(0, 8, 0, 1, 4'hF, "R8 capture edge");
    step(0, 9, 0, 1, 4'h0, "R8 capture edge");
    step(1, 10, 16'h1234, 1, 4'hF, "R8 capture beats write");
    step(1, 6, 16'h00F0, 0, 4'hF, "R9 set beats clear");
    step(1, 6, 16'h00F0, 0, 4'hF, "R9 clear");
    step(1, 3, 16'h0000, 0, 4'hF, "R3");
    for (int k = 0; k < 65540; k++) step(0, 7, 0, 1, 4'hF, "R3 wrap");
    step(0, 7, 0, 0, 4'hF, "R3 hold");
    for (int k = 0; k < 40000; k++) begin
      logic [3:0] a;
      logic [15:0] d;
      logic we;
      a = 4'($urandom_range(0, 11));
      we = ($urandom_range(0, 3) == 0);
      d = 16'($urandom);
      if (a >= 4'd8) d = m_cnt + 16'($urandom_range(0, 6));
      if (a == 4'd1 && $urandom_range(0, 2) != 0) we = 1'b0;
      step(we, a, d, 1'($urandom_range(0, 1)), 4'($urandom), "R4 R7 R8 R9 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule